// File: doc/BRIEF.md
# Triggered circular sample recorder

The recorder stores a stream of 64-bit debug samples into a ring of on-chip memory and stops a programmable time after a trigger pulse, so the memory ends up holding the history leading up to the event plus a chosen tail after it. Software writes one control word that holds the enable, an arm bit for one of two trigger sources, the post-trigger delay (a 7-bit count of power-of-two microsecond units) and a sample-rate code. The region of memory used is given as a base entry and a length in entries.

While a capture is in progress the arm bit reads back as set. Hardware clears it when the delay has expired and the last sample is stored. A status word then tells software whether the ring wrapped and which entry was written last, so the samples can be put back into time order. Any entry can be read as two 32-bit halves through a 4 KB window that is selected by a page number.

Top module: `dcap_top`

## Requirements
- R1: After reset, `ctrl_rd`, `status_o` and `rd_valid` are all zero.
- R2: A control write with bit 0 = 1 while no capture is running arms the recorder if bit 1 or bit 2 is set. `ctrl_rd[2:1]` then reads 01 (bit 1 wins when both are set) or 10. Arming also sets `status_o` to zero and moves the write pointer to `cfg_base`. A control write with bit 0 = 1 made while a capture runs is ignored. `ctrl_rd` returns the written word, with bits 2:1 showing the live arm state.
- R3: The rate code in control bits 22:20 thins the valid input samples. Code 7 stores every sample. Code c from 0 to 6 stores the first sample of each group of 2^(c+1), counting valid samples from arming.
- R4: Stored samples go to consecutive entries from `cfg_base`. A write into entry `cfg_base+cfg_size-1` sends the next write back to `cfg_base` and sets `status_o[31]`, which then stays set until the next arm.
- R5: `status_o[30:16]` holds the entry address of the last stored sample. `status_o[15:0]` is zero.
- R6: The delay is the count in control bits 14:8 times 2^u microseconds, where u is control bits 18:16 (7 is treated as 6). A microsecond is `TICK_DIV` clocks. With a trigger sampled at edge T and a count n > 0, the capture ends at edge T + n·2^u·TICK_DIV. A sample presented at that edge is still stored, and the arm bit is clear after that edge. A count of 0 ends the capture at T+1.
- R7: Only the first `trig_pulse` after arming is honoured. A later pulse does not move the end of the capture, and a pulse while not armed has no effect.
- R8: Samples presented while idle or after completion change neither the memory nor `status_o`.
- R9: A control write with bit 0 = 0 stops any capture at once and clears the arm bits. `status_o` is left unchanged and nothing more is stored.
- R10: A read with `rd_en` reaches entry {`rd_page`, `rd_off[11:3]`}. `rd_off[2]` = 0 returns sample bits 31:0 and 1 returns bits 63:32. The data and `rd_valid` appear one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word |
| ctrl_rd | output | 32 | Control readback with live arm bits |
| cfg_base | input | MEM_AW | First entry of the ring |
| cfg_size | input | MEM_AW+1 | Ring length in entries |
| smp_valid | input | 1 | Input sample valid |
| smp_data | input | 64 | Input sample |
| trig_pulse | input | 1 | Single-cycle trigger event |
| status_o | output | 32 | Wrap flag and last written entry |
| rd_en | input | 1 | Readback request |
| rd_page | input | MEM_AW-9 | Window page (entry bits above 8) |
| rd_off | input | 12 | Byte offset inside the 4 KB window |
| rd_valid | output | 1 | Readback data valid |
| rd_data | output | 32 | Readback half-sample |

## Verification
The trigger pulse and the wrap of the write pointer can land on the same clock edge. The bench provokes this by arming with every sample kept and timing the pulse so that it is sampled on the write into the last entry of a 16-entry ring. The ring has to wrap and the delay still has to run to the cycle. The expected status of wrap set with last entry base+2 is worked out by hand. Readback requests are also issued while writes are under way, and a cycle-exact bench model judges the status and arm bits on every cycle.

// File: rtl/dcap_pkg.sv
package dcap_pkg;
  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_ARMED = 2'd1,
    CS_POST  = 2'd2,
    CS_DONE  = 2'd3
  } cap_state_e;

  localparam int CB_EN       = 0;
  localparam int CB_ARM_A    = 1;
  localparam int CB_ARM_B    = 2;
  localparam int CB_CNT_LSB  = 8;
  localparam int CB_UNIT_LSB = 16;
  localparam int CB_RATE_LSB = 20;
  localparam int DLY_CNT_W   = 7;
  localparam int UNIT_W      = 3;
  localparam int RATE_W      = 3;
  localparam int UNIT_MAX    = 6;
  localparam int STAT_ADDR_W = 15;
endpackage

// File: rtl/dcap_decim.sv
module dcap_decim
  import dcap_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [RATE_W-1:0] rate,
  input  logic              in_valid,
  output logic              keep
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int b = 0; b < CNT_W; b++) begin
      if (b <= int'(rate)) mask[b] = 1'b1;
    end
  end

  assign keep = in_valid && ((rate == RATE_W'(7)) || ((cnt_q & mask) == '0));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (in_valid) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dcap_delay.sv
module dcap_delay
  import dcap_pkg::*;
#(
  parameter int TICK_DIV = 100
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 run,
  input  logic [DLY_CNT_W-1:0] cnt,
  input  logic [UNIT_W-1:0]    unit,
  output logic                 expire
);
  localparam int PSC_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int UCNT_W = UNIT_MAX + 1;

  logic [PSC_W-1:0]     psc_q;
  logic [UCNT_W-1:0]    ucnt_q;
  logic [DLY_CNT_W-1:0] dly_q;
  logic [UNIT_W-1:0]    unit_eff;
  logic [UCNT_W-1:0]    unit_last;
  logic                 us_tick;
  logic                 unit_tick;

  assign unit_eff  = (unit > UNIT_W'(UNIT_MAX)) ? UNIT_W'(UNIT_MAX) : unit;
  assign unit_last = (UCNT_W'(1) << unit_eff) - 1'b1;

  generate
    if (TICK_DIV > 1) begin : g_psc
      assign us_tick = (psc_q == PSC_W'(TICK_DIV - 1));
    end else begin : g_nopsc
      assign us_tick = 1'b1;
    end
  endgenerate

  assign unit_tick = us_tick && (ucnt_q == unit_last);
  assign expire    = (dly_q == '0) || ((dly_q == DLY_CNT_W'(1)) && unit_tick);

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_q  <= '0;
      ucnt_q <= '0;
      dly_q  <= '0;
    end else if (load) begin
      psc_q  <= '0;
      ucnt_q <= '0;
      dly_q  <= cnt;
    end else if (run) begin
      psc_q <= us_tick ? '0 : psc_q + 1'b1;
      if (us_tick) ucnt_q <= unit_tick ? '0 : ucnt_q + 1'b1;
      if (unit_tick && (dly_q != '0)) dly_q <= dly_q - 1'b1;
    end
  end
endmodule

// File: rtl/dcap_wptr.sv
module dcap_wptr #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] base,
  input  logic [AW:0]   size,
  output logic [AW-1:0] wp,
  output logic          wrap,
  output logic [AW-1:0] fin
);
  logic [AW:0] end_a;
  logic [AW:0] nxt;

  assign end_a = {1'b0, base} + size;
  assign nxt   = {1'b0, wp} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      wrap <= 1'b0;
      fin  <= '0;
    end else if (clr) begin
      wp   <= base;
      wrap <= 1'b0;
      fin  <= '0;
    end else if (we) begin
      fin <= wp;
      if (nxt >= end_a) begin
        wp   <= base;
        wrap <= 1'b1;
      end else begin
        wp <= nxt[AW-1:0];
      end
    end
  end
endmodule

// File: rtl/dcap_sdp.sv
module dcap_sdp #(
  parameter int AW = 10,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (re) rd <= mem[ra];
  end
endmodule

// File: rtl/dcap_top.sv
module dcap_top
  import dcap_pkg::*;
#(
  parameter int MEM_AW   = 10,
  parameter int SMP_W    = 64,
  parameter int TICK_DIV = 100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ctrl_we,
  input  logic [31:0]         ctrl_wdata,
  output logic [31:0]         ctrl_rd,
  input  logic [MEM_AW-1:0]   cfg_base,
  input  logic [MEM_AW:0]     cfg_size,
  input  logic                smp_valid,
  input  logic [SMP_W-1:0]    smp_data,
  input  logic                trig_pulse,
  output logic [31:0]         status_o,
  input  logic                rd_en,
  input  logic [MEM_AW-10:0]  rd_page,
  input  logic [11:0]         rd_off,
  output logic                rd_valid,
  output logic [31:0]         rd_data
);
  localparam int HALF_W = SMP_W / 2;
  localparam int PAD_W  = STAT_ADDR_W - MEM_AW;

  cap_state_e      state_q;
  logic [31:0]     ctrl_q;
  logic [1:0]      arm_q;
  logic            busy;
  logic            ctrl_act;
  logic            arm_go;
  logic            cap_en;
  logic            trig_take;
  logic            expire_w;
  logic            keep_w;
  logic [MEM_AW-1:0] wp_w;
  logic [MEM_AW-1:0] fin_w;
  logic            wrap_w;
  logic [SMP_W-1:0] ram_rd;
  logic            half_q;
  logic            rdv_q;

  assign busy      = (state_q == CS_ARMED) || (state_q == CS_POST);
  assign ctrl_act  = ctrl_we && (!ctrl_wdata[CB_EN] || !busy);
  assign arm_go    = ctrl_act && ctrl_wdata[CB_EN] &&
                     (ctrl_wdata[CB_ARM_A] || ctrl_wdata[CB_ARM_B]);
  assign cap_en    = busy && !ctrl_act;
  assign trig_take = cap_en && (state_q == CS_ARMED) && trig_pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CS_IDLE;
      ctrl_q  <= '0;
      arm_q   <= '0;
    end else if (ctrl_act) begin
      ctrl_q <= ctrl_wdata;
      if (!ctrl_wdata[CB_EN]) begin
        state_q <= CS_IDLE;
        arm_q   <= '0;
      end else if (arm_go) begin
        state_q <= CS_ARMED;
        arm_q   <= ctrl_wdata[CB_ARM_A] ? 2'b01 : 2'b10;
      end else begin
        arm_q <= '0;
      end
    end else if (trig_take) begin
      state_q <= CS_POST;
    end else if (cap_en && (state_q == CS_POST) && expire_w) begin
      state_q <= CS_DONE;
      arm_q   <= '0;
    end
  end

  assign ctrl_rd = {ctrl_q[31:3], arm_q, ctrl_q[CB_EN]};

  dcap_decim #(.CNT_W(7)) u_decim (
    .clk      (clk),
    .rst      (rst),
    .clr      (arm_go),
    .rate     (ctrl_q[CB_RATE_LSB +: RATE_W]),
    .in_valid (cap_en && smp_valid),
    .keep     (keep_w)
  );

  dcap_delay #(.TICK_DIV(TICK_DIV)) u_delay (
    .clk    (clk),
    .rst    (rst),
    .load   (trig_take),
    .run    (cap_en && (state_q == CS_POST)),
    .cnt    (ctrl_q[CB_CNT_LSB +: DLY_CNT_W]),
    .unit   (ctrl_q[CB_UNIT_LSB +: UNIT_W]),
    .expire (expire_w)
  );

  dcap_wptr #(.AW(MEM_AW)) u_wptr (
    .clk  (clk),
    .rst  (rst),
    .clr  (arm_go),
    .we   (keep_w),
    .base (cfg_base),
    .size (cfg_size),
    .wp   (wp_w),
    .wrap (wrap_w),
    .fin  (fin_w)
  );

  dcap_sdp #(.AW(MEM_AW), .DW(SMP_W)) u_ram (
    .clk (clk),
    .we  (keep_w),
    .wa  (wp_w),
    .wd  (smp_data),
    .re  (rd_en),
    .ra  ({rd_page, rd_off[11:3]}),
    .rd  (ram_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= 1'b0;
      rdv_q  <= 1'b0;
    end else begin
      rdv_q <= rd_en;
      if (rd_en) half_q <= rd_off[2];
    end
  end

  assign rd_valid = rdv_q;
  assign rd_data  = half_q ? ram_rd[SMP_W-1 -: HALF_W] : ram_rd[HALF_W-1:0];

  generate
    if (PAD_W > 0) begin : g_pad
      assign status_o = {wrap_w, {PAD_W{1'b0}}, fin_w, 16'h0000};
    end else begin : g_nopad
      assign status_o = {wrap_w, fin_w, 16'h0000};
    end
  endgenerate
endmodule

// File: rtl/dcap_checker.sv
module dcap_checker #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic [31:0]   ctrl_rd,
  input logic [31:0]   status_o,
  input logic [AW-1:0] base,
  input logic [AW:0]   size,
  input logic          mem_we,
  input logic [AW-1:0] mem_wa
);
  logic [AW:0] end_a;
  logic [AW-1:0] fin;
  assign end_a = {1'b0, base} + size;
  assign fin   = status_o[16 +: AW];

  assert_arm_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctrl_rd[2:1]));

  assert_stop_clears_arm_R9: assert property (@(posedge clk) disable iff (rst)
    !ctrl_rd[0] |-> (ctrl_rd[2:1] == 2'b00));

  assert_write_in_ring_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ((mem_wa >= base) && ({1'b0, mem_wa} < end_a)));

  assert_no_write_unarmed_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (ctrl_rd[2:1] != 2'b00));

  assert_wrap_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    ((ctrl_rd[2:1] != 2'b00) && status_o[31]) |=> status_o[31]);

  assert_finish_in_ring_R5: assert property (@(posedge clk) disable iff (rst)
    ((ctrl_rd[2:1] != 2'b00) && status_o[31]) |-> ((fin >= base) && ({1'b0, fin} < end_a)));
endmodule

bind dcap_top dcap_checker #(.AW(MEM_AW)) u_dcap_chk (
  .clk      (clk),
  .rst      (rst),
  .ctrl_rd  (ctrl_rd),
  .status_o (status_o),
  .base     (cfg_base),
  .size     (cfg_size),
  .mem_we   (keep_w),
  .mem_wa   (wp_w)
);

// File: tb/tb_dcap_top.sv
`timescale 1ns/1ps
module tb_dcap_top;
  localparam int AW = 10;
  localparam int TD = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic [31:0] ctrl_rd;
  logic [AW-1:0] cfg_base = '0;
  logic [AW:0] cfg_size = 11'd16;
  logic smp_valid = 1'b0;
  logic [63:0] smp_data = '0;
  logic trig_pulse = 1'b0;
  logic [31:0] status_o;
  logic rd_en = 1'b0;
  logic [AW-10:0] rd_page = '0;
  logic [11:0] rd_off = '0;
  logic rd_valid;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  int s_mode = 0;
  bit finished = 0;
  bit chk_on = 0;

  always #5 clk = ~clk;

  dcap_top #(.MEM_AW(AW), .SMP_W(64), .TICK_DIV(TD)) dut (.*);

  // reference model
  int m_state;
  logic [31:0] m_ctrl;
  logic [1:0] m_poll;
  int m_wp, m_fin, m_dec, m_left;
  bit m_wrap;
  logic [63:0] m_mem [1 << AW];
  bit m_wr [1 << AW];
  bit m_rdv, m_rdok;
  logic [31:0] m_rdd;

  function automatic logic [31:0] mk_ctrl(bit en, bit pa, bit pb, int cnt, int u, int rate);
    return (32'(rate & 7) << 20) | (32'(u & 7) << 16) | (32'(cnt & 127) << 8) |
           (32'(pb) << 2) | (32'(pa) << 1) | 32'(en);
  endfunction

  function automatic logic [31:0] stat_of(bit w, int f);
    return {w, 15'(f), 16'h0000};
  endfunction

  function automatic int kept_of(int code, int n);
    int m;
    m = (code == 7) ? 1 : (2 << code);
    return (n + m - 1) / m;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_ctrl = '0; m_poll = '0; m_wp = 0; m_fin = 0;
      m_dec = 0; m_left = 0; m_wrap = 0; m_rdv = 0;
      for (int i = 0; i < (1 << AW); i++) m_wr[i] = 0;
    end else begin
      bit busy, act, keep;
      int a, c, u;
      if (rd_en) begin
        a = {rd_page, rd_off[11:3]};
        m_rdv = 1; m_rdok = m_wr[a];
        m_rdd = rd_off[2] ? m_mem[a][63:32] : m_mem[a][31:0];
      end else m_rdv = 0;
      busy = (m_state == 1) || (m_state == 2);
      act = ctrl_we && (!ctrl_wdata[0] || !busy);
      if (act) begin
        m_ctrl = ctrl_wdata;
        if (!ctrl_wdata[0]) begin m_state = 0; m_poll = 0; end
        else if (ctrl_wdata[1] || ctrl_wdata[2]) begin
          m_state = 1; m_poll = ctrl_wdata[1] ? 2'b01 : 2'b10;
          m_wp = cfg_base; m_wrap = 0; m_fin = 0; m_dec = 0;
        end else m_poll = 0;
      end else if (busy) begin
        if (smp_valid) begin
          c = m_ctrl[22:20];
          keep = (c == 7) || ((m_dec % (2 << c)) == 0);
          m_dec++;
          if (keep) begin
            m_mem[m_wp] = smp_data; m_wr[m_wp] = 1; m_fin = m_wp;
            if (m_wp + 1 >= int'(cfg_base) + int'(cfg_size)) begin m_wp = cfg_base; m_wrap = 1; end
            else m_wp++;
          end
        end
        if (m_state == 1 && trig_pulse) begin
          m_state = 2;
          u = (m_ctrl[18:16] > 6) ? 6 : int'(m_ctrl[18:16]);
          m_left = int'(m_ctrl[14:8]) * TD * (1 << u);
        end else if (m_state == 2) begin
          if (m_left <= 1) begin m_state = 3; m_poll = 0; end
          else m_left--;
        end
      end
    end
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-exact comparison against the model
  always @(negedge clk) begin
    if (!rst && chk_on) begin
      chk(status_o == stat_of(m_wrap, m_fin), "R5 status", status_o, stat_of(m_wrap, m_fin));
      chk(ctrl_rd == {m_ctrl[31:3], m_poll, m_ctrl[0]}, "R6 ctrl/arm", ctrl_rd,
          {m_ctrl[31:3], m_poll, m_ctrl[0]});
      chk(rd_valid == m_rdv, "R10 rd_valid", rd_valid, m_rdv);
      if (m_rdv && m_rdok) chk(rd_data == m_rdd, "R10 rd_data", rd_data, m_rdd);
    end
  end

  // sample stream, driven just after the falling edge
  always @(negedge clk) begin
    #1;
    case (s_mode)
      1: begin smp_valid <= 1'b1; smp_data <= {$urandom, $urandom}; end
      2: begin smp_valid <= ($urandom % 4) != 0; smp_data <= {$urandom, $urandom}; end
      default: smp_valid <= 1'b0;
    endcase
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic ctrl(logic [31:0] w);
    ctrl_we = 1'b1; ctrl_wdata = w; @(negedge clk); ctrl_we = 1'b0;
  endtask
  task automatic pulse;
    trig_pulse = 1'b1; @(negedge clk); trig_pulse = 1'b0;
  endtask
  task automatic wait_done;
    int k;
    k = 0;
    while (ctrl_rd[2:1] != 2'b00 && k < 20000) begin @(negedge clk); k++; end
    chk(k < 20000, "R6 completion", k, 0);
  endtask
  task automatic readback(int b, int n);
    for (int e = b; e < b + n; e++) begin
      for (int h = 0; h < 2; h++) begin
        rd_en = 1'b1; rd_page = (AW-9)'(e >> 9); rd_off = {3'(e), 1'(h), 2'b00};
        @(negedge clk);
      end
    end
    rd_en = 1'b0; @(negedge clk);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] st0;
    void'($urandom(32'd4242));
    cyc(3); rst = 1'b0; @(negedge clk);
    // R1
    chk(ctrl_rd == 0, "R1 ctrl_rd", ctrl_rd, 0);
    chk(status_o == 0, "R1 status", status_o, 0);
    chk(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
    chk_on = 1;
    // R8: samples and trigger while idle
    s_mode = 1; cyc(20); pulse(); cyc(3); s_mode = 0; cyc(2);
    chk(status_o == 0, "R8 idle samples", status_o, 0);
    chk(ctrl_rd[2:1] == 0, "R7 idle trigger", ctrl_rd[2:1], 0);

    // R2 both arm bits: bit 1 wins; R6 count 0
    cfg_base = 10'd40; cfg_size = 11'd30;
    ctrl(mk_ctrl(1, 1, 1, 0, 0, 7));
    chk(ctrl_rd[2:1] == 2'b01, "R2 arm select", ctrl_rd[2:1], 2'b01);
    chk(status_o == 0, "R2 status cleared", status_o, 0);
    ctrl(mk_ctrl(1, 0, 1, 9, 2, 3));
    chk(ctrl_rd[14:8] == 0, "R2 write while busy ignored", ctrl_rd[14:8], 0);
    pulse();
    chk(ctrl_rd[1] == 1'b1, "R6 count0 still armed at T", ctrl_rd[1], 1);
    cyc(1);
    chk(ctrl_rd[2:1] == 0, "R6 count0 ends at T+1", ctrl_rd[2:1], 0);

    // R6/R7: count 3, unit 1 -> 18 cycles; second pulse ignored
    ctrl(mk_ctrl(1, 0, 1, 3, 1, 7));
    chk(ctrl_rd[2:1] == 2'b10, "R2 arm second source", ctrl_rd[2:1], 2'b10);
    s_mode = 2; cyc(5);
    pulse(); cyc(4); pulse(); cyc(12);
    chk(ctrl_rd[2] == 1'b1, "R7 still running at T+17", ctrl_rd[2], 1);
    cyc(1);
    chk(ctrl_rd[2:1] == 0, "R6 ends at T+18", ctrl_rd[2:1], 0);
    s_mode = 0;

    // R3 rate codes and R9 stop
    cfg_base = 10'd0; cfg_size = 11'd600;
    for (int c = 0; c < 8; c++) begin
      ctrl(mk_ctrl(1, 1, 0, 5, 0, c));
      s_mode = 1; cyc(37); s_mode = 0; cyc(2);
      ctrl(32'h0);
      chk(status_o == stat_of(0, kept_of(c, 37) - 1), "R3 rate thinning", status_o,
          stat_of(0, kept_of(c, 37) - 1));
      st0 = status_o;
      s_mode = 1; cyc(10); s_mode = 0; cyc(2);
      chk(status_o == st0, "R9 no writes after stop", status_o, st0);
      chk(ctrl_rd[2:1] == 0, "R9 arm cleared", ctrl_rd[2:1], 0);
    end

    // R4/R10: ring crossing a page boundary
    cfg_base = 10'd500; cfg_size = 11'd30;
    ctrl(mk_ctrl(1, 1, 0, 2, 0, 7));
    s_mode = 1; cyc(40); pulse(); wait_done(); s_mode = 0; cyc(2);
    chk(status_o[31] == 1'b1, "R4 wrap flag", status_o[31], 1);
    st0 = status_o;
    s_mode = 1; cyc(10); s_mode = 0; cyc(2);
    chk(status_o == st0, "R8 samples after done", status_o, st0);
    readback(500, 30);

    // trigger on the same edge as the wrap write
    cfg_base = 10'd100; cfg_size = 11'd16;
    ctrl(mk_ctrl(1, 1, 0, 1, 0, 7));
    s_mode = 1; cyc(15); pulse(); wait_done(); s_mode = 0; cyc(2);
    chk(status_o == stat_of(1, 102), "R4 trigger on wrap edge", status_o, stat_of(1, 102));
    readback(100, 16);

    // random captures with readback during capture
    for (int it = 0; it < 8; it++) begin
      int b, n;
      b = $urandom % 900;
      n = 4 + $urandom % (((1020 - b) < 200) ? (1020 - b) : 200);
      cfg_base = AW'(b); cfg_size = (AW+1)'(n);
      ctrl(mk_ctrl(1, $urandom % 2, 1, $urandom % 24, $urandom % 8, $urandom % 8));
      s_mode = 2;
      cyc($urandom % 60);
      readback(b, 3);
      pulse(); wait_done(); s_mode = 0; cyc(2);
      readback(b, (n < 12) ? n : 12);
    end
    cyc(3);
    summary();
  end
endmodule